// File: doc/BRIEF.md
# Hybrid Residue Magnitude-Index Accumulator

This block adds two numbers that are held in an extended hybrid notation. Each number has three parts. The first is a vector of residue digits over pairwise coprime moduli. Two of these moduli form the main residue range mu, and the third is a redundant modulus mR. The second part is a signed binary magnitude index, and the third is an unsigned binary control count. The block adds each part separately. Residue digits are added modulo their own modulus, and the index and control parts are added in plain binary. No conversion from residue to binary is done on any addition.

From the summed index J and the summed control count C, the block decides one of three outcomes. The sum may have left the signed range [-P, P). The redundancy held in the residue digits may be used up, in which case a normalization request is raised. Otherwise the sum is a legitimate result, which may be fed back as an operand of further additions. A normalized operand has a control count of 1, residue digits equal to (value mod mu) taken per modulus, and an index of floor(value / mu). With the default moduli 5, 7 and 9 (mu = 35, mR = 9), up to mR normalized values can be chained before a request is raised. Normalization itself is left to a separate unit.

Top module: `rmi_accum`

## Requirements
- R1: During and after a synchronous active-high reset, valid_out, ovf_out and norm_out are 0, and res_out, idx_out and ctl_out are all zero.
- R2: Each cycle in which valid_in is 1 produces a one-cycle pulse on valid_out at the next clock edge. When valid_in is 0, valid_out is 0 at the next edge.
- R3: The residue digits are packed as digit 0 mod 5 in bits [3:0], digit 1 mod 7 in bits [7:4] and digit 2 mod 9 in bits [11:8]. Each output digit equals (a digit + b digit) mod its modulus, and is always below that modulus.
- R4: idx_out is the two's-complement sum of a_idx and b_idx, and ctl_out is the unsigned sum of a_ctl and b_ctl, each truncated to its port width.
- R5: ovf_out is 1 exactly when J < I_minus + 1 - C or J > I_plus. Here J and C are the untruncated sums, I_minus = floor(-P/mu) and I_plus = floor((P-1)/mu). With P = 300 these give -9 and 8.
- R6: norm_out is 1 exactly when C > mR (9) and the overflow condition of R5 is false.
- R7: ovf_out and norm_out are never both 1. When both are 0 after normalized additions, the residue value r (0 <= r < 315) recovered from the three digits satisfies r + 35*J = the true integer sum.
- R8: While valid_in is 0, res_out, idx_out, ctl_out, ovf_out and norm_out keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operand pair is present |
| a_res | input | 12 | Residue digits of operand A |
| a_idx | input | 10 | Signed magnitude index of operand A |
| a_ctl | input | 5 | Control count of operand A |
| b_res | input | 12 | Residue digits of operand B |
| b_idx | input | 10 | Signed magnitude index of operand B |
| b_ctl | input | 5 | Control count of operand B |
| valid_out | output | 1 | Result registered this cycle |
| res_out | output | 12 | Residue digits of the sum |
| idx_out | output | 10 | Magnitude index of the sum |
| ctl_out | output | 5 | Control count of the sum |
| ovf_out | output | 1 | Range overflow detected |
| norm_out | output | 1 | Normalization needed |

## Verification
Every result (sum fields and both flags) is due exactly one clock edge after the cycle in which valid_in was 1, together with the valid_out pulse. The driver applies operands on a falling edge and queues the expected tuple. The monitor samples on the next falling edge, pops the queue only when valid_out is 1, and in idle cycles compares the held outputs against the last item it popped. Expected tuples come from an integer model that builds normalized operands from plain integers and recovers the sum's value by a search over the residue digits.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
  // floor(n / d) for d > 0, for any sign of n
  function automatic int floor_div(input int n, input int d);
    if (n >= 0) return n / d;
    else        return -((-n + d - 1) / d);
  endfunction
endpackage

// File: rtl/rmi_modadd.sv
module rmi_modadd #(
  parameter int RW   = 4,
  parameter int MODV = 5
) (
  input  logic [RW-1:0] a,
  input  logic [RW-1:0] b,
  output logic [RW-1:0] s
);
  logic [RW:0] raw;
  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    if (raw >= (RW+1)'(MODV)) s = RW'(raw - (RW+1)'(MODV));
    else                      s = raw[RW-1:0];
  end
endmodule

// File: rtl/rmi_ovf_det.sv
module rmi_ovf_det #(
  parameter int IW      = 10,
  parameter int CW      = 5,
  parameter int I_MINUS = -9,
  parameter int I_PLUS  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW:0]   j_sum,
  input  logic [CW:0]   c_sum,
  output logic          ovf
);
  localparam int DW = IW + 3;

  logic [IW-1:0] iplus_q, imin1_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      iplus_q <= IW'(I_PLUS);
      imin1_q <= IW'(I_MINUS + 1);
    end
  end

  logic [DW-1:0] j_x, c_x, ip_x, im_x, d_lo, d_hi;
  always_comb begin
    j_x  = {{2{j_sum[IW]}}, j_sum};
    c_x  = {{(DW-CW-1){1'b0}}, c_sum};
    ip_x = {{(DW-IW){iplus_q[IW-1]}}, iplus_q};
    im_x = {{(DW-IW){imin1_q[IW-1]}}, imin1_q};
    d_lo = j_x - (im_x - c_x);
    d_hi = ip_x - j_x;
    ovf  = d_lo[DW-1] | d_hi[DW-1];
  end
endmodule

// File: rtl/rmi_norm_req.sv
module rmi_norm_req #(
  parameter int CW   = 5,
  parameter int MR   = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [CW:0] c_sum,
  input  logic        ovf,
  output logic        norm
);
  localparam int SW = CW + 2;

  logic [SW-1:0] bias_q, probe;
  always_ff @(posedge clk) begin
    if (rst) bias_q <= SW'(-(MR + 1));
  end

  always_comb begin
    probe = {1'b0, c_sum} + bias_q;
    norm  = ~(probe[SW-1] | ovf);
  end
endmodule

// File: rtl/rmi_accum.sv
module rmi_accum #(
  parameter int MOD_A   = 5,
  parameter int MOD_B   = 7,
  parameter int MOD_R   = 9,
  parameter int RW      = 4,
  parameter int IW      = 10,
  parameter int CW      = 5,
  parameter int RANGE_P = 300
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic [3*RW-1:0]      a_res,
  input  logic [IW-1:0]        a_idx,
  input  logic [CW-1:0]        a_ctl,
  input  logic [3*RW-1:0]      b_res,
  input  logic [IW-1:0]        b_idx,
  input  logic [CW-1:0]        b_ctl,
  output logic                 valid_out,
  output logic [3*RW-1:0]      res_out,
  output logic [IW-1:0]        idx_out,
  output logic [CW-1:0]        ctl_out,
  output logic                 ovf_out,
  output logic                 norm_out
);
  import rmi_pkg::*;
  localparam int NMOD    = 3;
  localparam int MU      = MOD_A * MOD_B;
  localparam int I_MINUS = floor_div(-RANGE_P, MU);
  localparam int I_PLUS  = floor_div(RANGE_P - 1, MU);
  localparam int MODS [NMOD] = '{MOD_A, MOD_B, MOD_R};

  logic [NMOD*RW-1:0] res_sum;
  for (genvar k = 0; k < NMOD; k++) begin : g_dig
    rmi_modadd #(.RW(RW), .MODV(MODS[k])) u_add (
      .a(a_res[k*RW +: RW]),
      .b(b_res[k*RW +: RW]),
      .s(res_sum[k*RW +: RW])
    );
  end

  logic [IW:0] j_sum;
  logic [CW:0] c_sum;
  assign j_sum = {a_idx[IW-1], a_idx} + {b_idx[IW-1], b_idx};
  assign c_sum = {1'b0, a_ctl} + {1'b0, b_ctl};

  logic ovf_c, norm_c;
  rmi_ovf_det #(.IW(IW), .CW(CW), .I_MINUS(I_MINUS), .I_PLUS(I_PLUS)) u_ovf (
    .clk(clk), .rst(rst), .j_sum(j_sum), .c_sum(c_sum), .ovf(ovf_c)
  );

  rmi_norm_req #(.CW(CW), .MR(MOD_R)) u_norm (
    .clk(clk), .rst(rst), .c_sum(c_sum), .ovf(ovf_c), .norm(norm_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      res_out   <= '0;
      idx_out   <= '0;
      ctl_out   <= '0;
      ovf_out   <= 1'b0;
      norm_out  <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        res_out  <= res_sum;
        idx_out  <= j_sum[IW-1:0];
        ctl_out  <= c_sum[CW-1:0];
        ovf_out  <= ovf_c;
        norm_out <= norm_c;
      end
    end
  end
endmodule

// File: rtl/rmi_accum_chk.sv
module rmi_accum_chk #(
  parameter int MOD_A   = 5,
  parameter int MOD_B   = 7,
  parameter int MOD_R   = 9,
  parameter int RW      = 4,
  parameter int IW      = 10,
  parameter int CW      = 5,
  parameter int RANGE_P = 300
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_in,
  input logic [3*RW-1:0] a_res,
  input logic [IW-1:0]   a_idx,
  input logic [CW-1:0]   a_ctl,
  input logic [3*RW-1:0] b_res,
  input logic [IW-1:0]   b_idx,
  input logic [CW-1:0]   b_ctl,
  input logic            valid_out,
  input logic [3*RW-1:0] res_out,
  input logic [IW-1:0]   idx_out,
  input logic [CW-1:0]   ctl_out,
  input logic            ovf_out,
  input logic            norm_out
);
  import rmi_pkg::*;
  localparam int I_PLUS = floor_div(RANGE_P - 1, MOD_A * MOD_B);

  logic unused_ok;
  assign unused_ok = ^{a_res, b_res, idx_out, ctl_out};

  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  a_r3_digit0: assert property (@(posedge clk) disable iff (rst)
    int'(res_out[RW-1:0]) < MOD_A);
  a_r3_digit1: assert property (@(posedge clk) disable iff (rst)
    int'(res_out[2*RW-1:RW]) < MOD_B);
  a_r3_digit2: assert property (@(posedge clk) disable iff (rst)
    int'(res_out[3*RW-1:2*RW]) < MOD_R);
  a_r5_upper: assert property (@(posedge clk) disable iff (rst)
    (valid_in && (int'($signed(a_idx)) + int'($signed(b_idx)) > I_PLUS)) |=> ovf_out);
  a_r6_spent: assert property (@(posedge clk) disable iff (rst)
    (valid_in && (int'(a_ctl) + int'(b_ctl) > MOD_R)) |=> (ovf_out || norm_out));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ovf_out && norm_out));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(res_out) && $stable(idx_out) && $stable(ctl_out)
                   && $stable(ovf_out) && $stable(norm_out)));
endmodule

bind rmi_accum rmi_accum_chk #(
  .MOD_A(MOD_A), .MOD_B(MOD_B), .MOD_R(MOD_R), .RW(RW), .IW(IW), .CW(CW),
  .RANGE_P(RANGE_P)
) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in),
  .a_res(a_res), .a_idx(a_idx), .a_ctl(a_ctl),
  .b_res(b_res), .b_idx(b_idx), .b_ctl(b_ctl),
  .valid_out(valid_out), .res_out(res_out), .idx_out(idx_out),
  .ctl_out(ctl_out), .ovf_out(ovf_out), .norm_out(norm_out)
);

// File: tb/rmi_accum_tb.sv
module rmi_accum_tb;
  localparam int P = 300;
  localparam int MU = 35;
  localparam int IMIN = -9;   // floor(-300/35)
  localparam int IPLS = 8;    // floor(299/35)

  typedef struct packed {
    logic [11:0]       res;
    logic signed [9:0] idx;
    logic [4:0]        ctl;
  } tup_t;

  typedef struct {
    tup_t t;
    bit   ovf;
    bit   norm;
    bit   has_tot;
    int   tot;
  } exp_t;

  logic clk = 0, rst = 1, valid_in = 0;
  logic [11:0] a_res = 0, b_res = 0;
  logic [9:0]  a_idx = 0, b_idx = 0;
  logic [4:0]  a_ctl = 0, b_ctl = 0;
  logic valid_out, ovf_out, norm_out;
  logic [11:0] res_out;
  logic [9:0]  idx_out;
  logic [4:0]  ctl_out;

  always #5 clk = ~clk;

  rmi_accum u_dut (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .a_res(a_res), .a_idx(a_idx), .a_ctl(a_ctl),
    .b_res(b_res), .b_idx(b_idx), .b_ctl(b_ctl),
    .valid_out(valid_out), .res_out(res_out), .idx_out(idx_out),
    .ctl_out(ctl_out), .ovf_out(ovf_out), .norm_out(norm_out)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];
  exp_t last;
  bit have_last = 0;

  function automatic int fdiv(int n, int d);
    if (n >= 0) return n / d;
    return -((-n + d - 1) / d);
  endfunction

  function automatic tup_t mk(int v);
    tup_t t;
    int ix, r;
    ix = fdiv(v, MU);
    r  = v - MU * ix;
    t.res = {4'(r % 9), 4'(r % 7), 4'(r % 5)};
    t.idx = 10'(ix);
    t.ctl = 5'd1;
    return t;
  endfunction

  function automatic exp_t add(tup_t a, tup_t b);
    exp_t e;
    int j, c;
    j = int'(a.idx) + int'(b.idx);
    c = int'(a.ctl) + int'(b.ctl);
    e.t.res = {4'((a.res[11:8] + b.res[11:8]) % 9),
               4'((a.res[7:4]  + b.res[7:4])  % 7),
               4'((a.res[3:0]  + b.res[3:0])  % 5)};
    e.t.idx = 10'(j);
    e.t.ctl = 5'(c);
    e.ovf   = (j < IMIN + 1 - c) || (j > IPLS);
    e.norm  = (c > 9) && !e.ovf;
    e.has_tot = 0;
    e.tot     = 0;
    return e;
  endfunction

  function automatic int crt(logic [11:0] r);
    for (int v = 0; v < 315; v++)
      if (v % 5 == int'(r[3:0]) && v % 7 == int'(r[7:4]) && v % 9 == int'(r[11:8]))
        return v;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(tup_t a, tup_t b, bit ht, int tot, output tup_t s);
    exp_t e;
    @(negedge clk);
    a_res = a.res; a_idx = a.idx; a_ctl = a.ctl;
    b_res = b.res; b_idx = b.idx; b_ctl = b.ctl;
    valid_in = 1;
    e = add(a, b);
    e.has_tot = ht;
    e.tot = tot;
    q.push_back(e);
    s = e.t;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_in = 0;
      a_res = 12'hfff; b_idx = 10'h155;   // changes that must have no effect (R8)
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        if (valid_out) begin
          exp_t e;
          if (q.size() == 0) begin
            chk(0, "R2", "unexpected valid_out", 1, 0);
          end else begin
            e = q.pop_front();
            chk(res_out == e.t.res, "R3", "residue digits", int'(res_out), int'(e.t.res));
            chk(idx_out == e.t.idx, "R4", "index", int'($signed(idx_out)), int'(e.t.idx));
            chk(ctl_out == e.t.ctl, "R4", "control", int'(ctl_out), int'(e.t.ctl));
            chk(ovf_out == e.ovf, "R5", "overflow", int'(ovf_out), int'(e.ovf));
            chk(norm_out == e.norm, "R6", "normalize", int'(norm_out), int'(e.norm));
            chk(!(ovf_out && norm_out), "R7", "flags exclusive", 1, 0);
            if (e.has_tot && !e.ovf && !e.norm)
              chk(crt(res_out) + MU * int'($signed(idx_out)) == e.tot, "R7",
                  "legitimate value", crt(res_out) + MU * int'($signed(idx_out)), e.tot);
            last = e;
            have_last = 1;
          end
        end else if (have_last) begin
          chk(res_out == last.t.res && idx_out == last.t.idx && ctl_out == last.t.ctl
              && ovf_out == last.ovf && norm_out == last.norm,
              "R8", "hold while idle", int'(res_out), int'(last.t.res));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tup_t s, acc, tmp;
    int tot;
    int unsigned seed;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(valid_out == 0 && ovf_out == 0 && norm_out == 0, "R1", "flags in reset",
        int'({valid_out, ovf_out, norm_out}), 0);
    chk(res_out == 0 && idx_out == 0 && ctl_out == 0, "R1", "fields in reset",
        int'(res_out), 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(valid_out == 0 && res_out == 0, "R1", "state after reset", int'(valid_out), 0);

    // R3/R4 simple legitimate sums
    drive(mk(10), mk(20), 1, 30, s);
    drive(mk(-50), mk(17), 1, -33, s);
    idle(3);

    // R5 upper boundary: J = 8 legit, J = 10 overflow
    drive(mk(290), mk(10), 1, 300, s);
    drive(mk(280), mk(70), 1, 350, s);
    // R5 lower boundary: J = -10 at bound, J = -11 overflow
    drive(mk(-300), mk(-35), 1, -335, s);
    drive(mk(-300), mk(-70), 1, -370, s);
    idle(2);

    // R6/R7: chain normalized 34s up to mR, then one more
    acc = mk(34); tot = 34;
    for (int i = 2; i <= 10; i++) begin
      tot += 34;
      drive(acc, mk(34), 1, tot, tmp);
      acc = tmp;
    end
    idle(2);
    // chain of -1s (negative legitimate accumulation)
    acc = mk(-1); tot = -1;
    for (int i = 2; i <= 9; i++) begin
      tot -= 1;
      drive(acc, mk(-1), 1, tot, tmp);
      acc = tmp;
    end
    idle(2);

    // R7: both conditions present, overflow wins
    acc.res = 12'h0; acc.idx = 10'sd8; acc.ctl = 5'd9;
    tmp.res = 12'h0; tmp.idx = 10'sd2; tmp.ctl = 5'd1;
    drive(acc, tmp, 0, 0, s);
    idle(2);

    // random normalized pairs
    seed = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      int x, y;
      seed = seed * 1103515245 + 12345;
      x = int'((seed >> 8) % 600) - P;
      seed = seed * 1103515245 + 12345;
      y = int'((seed >> 8) % 600) - P;
      drive(mk(x), mk(y), 1, x + y, s);
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    chk(q.size() == 0, "R2", "all results returned", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule